// File: doc/BRIEF.md
# Fractional UART Bit-Rate Generator

This block turns a fixed 24 MHz reference clock into the bit-rate timing for a UART. It takes three configuration inputs. An integer divisor and a small fractional adjust together set the length of one bit period in reference cycles. A line-control word selects the character length, the number of stop bits and the parity mode.

It has three kinds of output. A one-cycle tick marks the end of each bit period. A word-time value gives the length of one character in bit periods. Decoded frame fields tell the transmitter and receiver how to build and check each character.

The configuration is sampled every cycle. Any change to it restarts the bit-period count, so the first tick under the new settings comes one full new period later. A divisor of zero stops the tick completely.

Top module: `uart_baud_gen`

## Requirements
- R1: While the configuration is steady and the divisor is nonzero, ticks repeat every 16*div_i + frac_i + 16 reference cycles. The divisor field is DIV_W bits wide (16 by default) and the fractional field is FRAC_W bits wide (3 by default).
- R2: While div_i is zero, tick_o stays low.
- R3: data_bits_o equals lcr_i[1:0] + 5, which gives 5 to 8 data bits.
- R4: two_stop_o equals lcr_i[2]: set means two stop bits, clear means one.
- R5: parity_en_o equals lcr_i[5]. When parity is enabled, lcr_i[3] set selects even parity and lcr_i[3] clear selects odd parity. lcr_i[4] has no effect on any output. parity_even_o is low whenever parity is disabled.
- R6: word_bits_o equals the data bits plus the stop bits plus one start bit. The parity bit is not counted.
- R7: A change to div_i, frac_i or lcr_i is seen at the next clock edge, and that edge restarts the count. The first tick under the new settings is high after the P-th edge that follows the edge that saw the change, where P is the new period.
- R8: tick_o is a single-cycle pulse. It is never high on two consecutive cycles.
- R9: Right after reset, tick_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock (24 MHz) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Integer divisor |
| frac_i | input | FRAC_W | Fractional adjust, added in reference cycles |
| lcr_i | input | 6 | Line control: [1:0] length, [2] stop bits, [3] even parity, [5] parity enable |
| tick_o | output | 1 | One-cycle pulse at the end of each bit period |
| data_bits_o | output | 4 | Number of data bits, 5 to 8 |
| two_stop_o | output | 1 | Set when two stop bits are used |
| parity_en_o | output | 1 | Parity bit present |
| parity_even_o | output | 1 | Even parity selected (low when parity is off) |
| word_bits_o | output | 4 | Character length in bit periods |

## Verification
The bench builds the block with DIV_W = 8 and FRAC_W = 3. At that width the largest divisor, 255 with fractional value 7, gives a period of 4103 cycles, so the top of the divisor range can be measured tick to tick within the run. The smallest periods of 32 to 39 cycles make it cheap to check restart latency and pulse width over many repetitions. The narrower divisor does not change the period arithmetic, because each field keeps its shift and offset.

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [5:0]        lcr_i,
  output logic              tick_o,
  output logic [3:0]        data_bits_o,
  output logic              two_stop_o,
  output logic              parity_en_o,
  output logic              parity_even_o,
  output logic [3:0]        word_bits_o
);

  localparam int PER_W = ((DIV_W + 4 > FRAC_W) ? DIV_W + 4 : FRAC_W) + 1;
  localparam int CFG_W = DIV_W + FRAC_W + 6;

  logic [CFG_W-1:0] cfg, cfg_q;
  logic [PER_W-1:0] period, cnt;
  logic             changed, div_zero;

  assign cfg      = {div_i, frac_i, lcr_i};
  assign changed  = (cfg != cfg_q);
  assign div_zero = (div_i == '0);
  assign period   = {{(PER_W-DIV_W-4){1'b0}}, div_i, 4'b0000}
                  + {{(PER_W-FRAC_W){1'b0}}, frac_i}
                  + PER_W'(16);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      cnt    <= '0;
      tick_o <= 1'b0;
    end else begin
      cfg_q <= cfg;
      if (changed || div_zero) begin
        cnt    <= '0;
        tick_o <= 1'b0;
      end else if (cnt == period - PER_W'(1)) begin
        cnt    <= '0;
        tick_o <= 1'b1;
      end else begin
        cnt    <= cnt + PER_W'(1);
        tick_o <= 1'b0;
      end
    end
  end

  assign data_bits_o   = {2'b00, lcr_i[1:0]} + 4'd5;
  assign two_stop_o    = lcr_i[2];
  assign parity_en_o   = lcr_i[5];
  assign parity_even_o = lcr_i[5] & lcr_i[3];
  assign word_bits_o   = data_bits_o + (lcr_i[2] ? 4'd3 : 4'd2);

  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!changed && !div_zero) |-> (cnt < period))
    else $error("count beyond period");

  p_zero_div_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_zero |=> !tick_o)
    else $error("tick while divisor is zero");

  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    changed |=> (!tick_o && cnt == '0))
    else $error("config change did not restart");

  p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o)
    else $error("tick wider than one cycle");

  always_comb begin
    if (rst_ni) begin
      p_len_range_r3: assert (data_bits_o >= 4'd5 && data_bits_o <= 4'd8)
        else $error("data bits out of range");
    end
  end

endmodule

// File: tb/uart_baud_gen_tb_top.sv
module uart_baud_gen_tb_top;
  localparam int DIV_W  = 8;
  localparam int FRAC_W = 3;
  localparam int NV = 6;

  localparam int V_DIV [NV]  = '{1, 1, 2, 3, 255, 5};
  localparam int V_FRAC[NV]  = '{0, 7, 3, 1, 7, 0};
  localparam int V_LCR [NV]  = '{6'b000000, 6'b000011, 6'b000111, 6'b101001, 6'b100010, 6'b110000};
  localparam int V_PER [NV]  = '{32, 39, 51, 65, 4103, 96};
  localparam int V_DATA[NV]  = '{5, 8, 8, 6, 7, 5};
  localparam int V_STOP2[NV] = '{0, 0, 1, 0, 0, 0};
  localparam int V_PEN [NV]  = '{0, 0, 0, 1, 1, 1};
  localparam int V_PEV [NV]  = '{0, 0, 0, 1, 0, 0};
  localparam int V_WORD[NV]  = '{7, 10, 11, 8, 9, 7};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic [FRAC_W-1:0] frac = '0;
  logic [5:0] lcr = '0;
  logic tick, two_stop, par_en, par_even;
  logic [3:0] data_bits, word_bits;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_baud_gen #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .frac_i(frac), .lcr_i(lcr),
    .tick_o(tick), .data_bits_o(data_bits), .two_stop_o(two_stop),
    .parity_en_o(par_en), .parity_even_o(par_even), .word_bits_o(word_bits));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    for (int k = 0; k < 10000; k++) begin
      @(posedge clk); #1;
      n++;
      if (tick) return;
    end
    n = -1;
  endtask

  task automatic drive(int d, int f, int l);
    @(negedge clk);
    div = DIV_W'(d); frac = FRAC_W'(f); lcr = 6'(l);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int n, hi;
    repeat (3) @(posedge clk);
    #1; check("R9 tick after reset", int'(tick), 0);
    rst_n = 1'b1;

    // R2: zero divisor gives no ticks
    hi = 0;
    for (int k = 0; k < 300; k++) begin
      @(posedge clk); #1;
      if (tick) hi++;
    end
    check("R2 ticks with zero divisor", hi, 0);

    for (int v = 0; v < NV; v++) begin
      drive(V_DIV[v], V_FRAC[v], V_LCR[v]);
      #1;
      check("R3 data bits", int'(data_bits), V_DATA[v]);
      check("R4 stop bits", int'(two_stop), V_STOP2[v]);
      check("R5 parity enable", int'(par_en), V_PEN[v]);
      check("R5 parity even", int'(par_even), V_PEV[v]);
      check("R6 word time", int'(word_bits), V_WORD[v]);
      wait_tick(n);
      check("R7 first tick latency", n, V_PER[v] + 1);
      wait_tick(n);
      check("R1 tick period", n, V_PER[v]);
      @(posedge clk); #1;
      check("R8 tick falls", int'(tick), 0);
      wait_tick(n);
      check("R1 tick period repeat", n, V_PER[v] - 1);
    end

    // R7: line-control-only change mid-period restarts the count
    drive(1, 0, 0);
    wait_tick(n);
    repeat (10) @(posedge clk);
    drive(1, 0, 6'b000100);
    wait_tick(n);
    check("R7 restart on line-control change", n, 33);

    // R7: fractional-only change restarts with the new period
    repeat (5) @(posedge clk);
    drive(1, 2, 6'b000100);
    wait_tick(n);
    check("R7 restart on fraction change", n, 35);

    // R5: lcr bit 4 has no effect on any output
    drive(1, 2, 6'b111011);
    #1;
    check("R5 bit4 parity even", int'(par_even), 1);
    check("R5 bit4 word", int'(word_bits), 10);
    wait_tick(n);
    wait_tick(n);
    check("R5 bit4 period unchanged", n, 34);

    // R2: divisor back to zero stops ticking
    drive(0, 5, 0);
    hi = 0;
    for (int k = 0; k < 200; k++) begin
      @(posedge clk); #1;
      if (tick) hi++;
    end
    check("R2 ticks after divisor cleared", hi, 0);

    finish_run();
  end
endmodule